// File: doc/BRIEF.md
# Minicomputer Bus Address Decoder

This block sits between a 16-bit word-oriented processor and the targets on its 18-bit physical bus. Each accepted request is a word or byte read or write. The block decides which target the request reaches: main memory, a small set of single-address registers, or one of four device windows. It strobes that target and returns a response. Misaligned word accesses, unmapped addresses and writes to read-only locations produce a one-cycle bus-error pulse, and the offending address is kept for the trap handler.

Byte accesses always travel as word accesses. On a read, the block picks the addressed half of the aligned word. A byte write to memory uses byte enables. A byte write to a device window is done as a word read of the device, followed one cycle later by a full-word write-back of the merged value. The block holds two registers of its own: the line-clock status register and the processor status word. Every write to the status word has its two mode fields checked. The current and previous execution modes are driven out as plain outputs.

Requests use valid/ready. A request is taken on a rising edge where both `req_valid` and `req_ready` are high. The requester must hold `req_valid` and its fields steady until that edge. `req_ready` is low only while a device read-modify-write is in progress. Responses carry no back-pressure: `rsp_valid` is high for exactly one cycle and must be consumed then.

Top module: `bus_addr_decoder`

## Requirements
- R1: An address below octal 0760000 reaches memory. `mem_req` is high in the cycle the request is accepted, and `mem_addr` is the byte address shifted right by one. Read data from memory is returned.
- R2: A word access with address bit 0 set raises `bus_trap` and strobes no target. `fault_addr` then holds the request address.
- R3: These accesses raise `bus_trap`: any access that matches no region, a write to the constant switch register (0777570), and a write to MMU status register 2 (0777576). The read data of a trapped access is 0.
- R4: The single-address registers are 0777546 for line-clock status (read/write, reset 0), 0777570 for the switch register (always reads `SWITCH_VAL`, default 0173030), 0777572 for MMU status 0 (read/write), 0777576 for MMU status 2 (read only) and 0777776 for the status word.
- R5: Four device windows are selected on the one-hot `dev_sel`: bit 0 is the console (address AND 0777770 = 0777560), bit 1 is the disk (AND 0777760 = 0777400), bit 2 is the MMU page registers (AND 0777600 = 0772200 or 0777600), and bit 3 is MMU status 0 and 2. Decode order is memory, then the single addresses, then the windows, so 0777776 reaches the status word.
- R6: A byte read returns the high byte of the aligned word for an odd address and the low byte for an even address, in bits 7:0 with bits 15:8 zero.
- R7: A byte write to memory sets only `mem_be` bit 1 (odd address) or bit 0 (even address). The data byte is replicated on both lanes of `mem_wdata`.
- R8: A byte write to a device window reads the aligned word with `dev_re` in the accept cycle. In the next cycle it writes back the merged word with `dev_we`. The response follows the write-back, two cycles after acceptance.
- R9: On a write to the status word, bits 15:14 set the current mode and bits 13:12 set the previous mode. In each field, 0 means kernel and 3 means user. A value of 1 or 2 in either field raises `mode_err`, leaves the word unchanged and does not trap. `cur_user` and `prev_user` are high for user mode. The status word resets to 0.
- R10: Every access that is not a device byte write responds one cycle after acceptance. `bus_trap` and `mode_err` are high only in the cycle of their response, and `rsp_err` is high with them.
- R11: `busy` is high during the write-back cycle of R8, and `req_ready` is low whenever `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_byte | input | 1 | 1 = byte access, 0 = word access |
| req_addr | input | AW | Physical byte address |
| req_wdata | input | DW | Write data (byte in bits 7:0) |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | DW | Read result |
| rsp_err | output | 1 | Response carries a trap or mode error |
| busy | output | 1 | Device write-back in progress |
| bus_trap | output | 1 | Bus-error pulse |
| mode_err | output | 1 | Invalid-mode pulse |
| fault_addr | output | AW | Address of the last trapped access |
| mem_req | output | 1 | Memory strobe |
| mem_we | output | 1 | Memory write enable |
| mem_be | output | 2 | Memory byte-lane enables |
| mem_addr | output | AW-1 | Memory word index |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, same cycle |
| dev_sel | output | 4 | One-hot device window select |
| dev_re | output | 1 | Device read strobe |
| dev_we | output | 1 | Device write strobe |
| dev_addr | output | AW | Word-aligned device address |
| dev_wdata | output | DW | Device write data |
| dev_rdata | input | DW | Device read data, same cycle |
| psw | output | DW | Processor status word |
| cur_user | output | 1 | Current mode is user |
| prev_user | output | 1 | Previous mode is user |

## Verification
The bench builds the block with its defaults: AW = 18, DW = 16 and SWITCH_VAL = 0173030. With these values the octal map above is reachable exactly, including the overlap where the status word also lies inside the MMU page window. Small stubs for memory and devices decode only the low address bits, so the bench can reach every region and write-protected address, and the read-modify-write path, in a few hundred cycles. The constant read from the switch register is checked against the default SWITCH_VAL.

// File: rtl/bus_dec_pkg.sv
`timescale 1ns/1ps
package bus_dec_pkg;
  typedef enum logic [3:0] {
    TGT_MEM, TGT_LCLK, TGT_SWR, TGT_SR0, TGT_SR2,
    TGT_PSW, TGT_CONS, TGT_DISK, TGT_MMUPG, TGT_NONE
  } tgt_e;

  localparam int NDEV      = 4;
  localparam int DEV_CONS  = 0;
  localparam int DEV_DISK  = 1;
  localparam int DEV_MMUPG = 2;
  localparam int DEV_MMUST = 3;
endpackage

// File: rtl/bus_dec_region.sv
`timescale 1ns/1ps
module bus_dec_region
  import bus_dec_pkg::*;
#(
  parameter int AW = 18
) (
  input  logic [AW-1:0] addr_al,
  output tgt_e          tgt,
  output logic          writable
);
  localparam logic [AW-1:0] MEM_LIMIT = AW'(18'o760000);
  localparam logic [AW-1:0] A_LCLK    = AW'(18'o777546);
  localparam logic [AW-1:0] A_SWR     = AW'(18'o777570);
  localparam logic [AW-1:0] A_SR0     = AW'(18'o777572);
  localparam logic [AW-1:0] A_SR2     = AW'(18'o777576);
  localparam logic [AW-1:0] A_PSW     = AW'(18'o777776);
  localparam logic [AW-1:0] M_CONS    = AW'(18'o777770);
  localparam logic [AW-1:0] B_CONS    = AW'(18'o777560);
  localparam logic [AW-1:0] M_DISK    = AW'(18'o777760);
  localparam logic [AW-1:0] B_DISK    = AW'(18'o777400);
  localparam logic [AW-1:0] M_PAGE    = AW'(18'o777600);
  localparam logic [AW-1:0] B_PAGE_LO = AW'(18'o772200);
  localparam logic [AW-1:0] B_PAGE_HI = AW'(18'o777600);

  function automatic logic in_win(input logic [AW-1:0] a, input logic [AW-1:0] m,
                                  input logic [AW-1:0] b);
    return (a & m) == b;
  endfunction

  always_comb begin
    if (addr_al < MEM_LIMIT)                 tgt = TGT_MEM;
    else if (addr_al == A_LCLK)              tgt = TGT_LCLK;
    else if (addr_al == A_SWR)               tgt = TGT_SWR;
    else if (addr_al == A_SR0)               tgt = TGT_SR0;
    else if (addr_al == A_SR2)               tgt = TGT_SR2;
    else if (addr_al == A_PSW)               tgt = TGT_PSW;
    else if (in_win(addr_al, M_CONS, B_CONS)) tgt = TGT_CONS;
    else if (in_win(addr_al, M_DISK, B_DISK)) tgt = TGT_DISK;
    else if (in_win(addr_al, M_PAGE, B_PAGE_LO) || in_win(addr_al, M_PAGE, B_PAGE_HI))
                                             tgt = TGT_MMUPG;
    else                                     tgt = TGT_NONE;
    writable = !(tgt == TGT_SWR || tgt == TGT_SR2 || tgt == TGT_NONE);
  end
endmodule

// File: rtl/bus_dec_lane.sv
`timescale 1ns/1ps
module bus_dec_lane #(
  parameter int DW = 16
) (
  input  logic [DW-1:0]   word_i,
  input  logic            hi_i,
  input  logic [DW/2-1:0] byte_i,
  output logic [DW-1:0]   pick_o,
  output logic [DW-1:0]   merge_o
);
  localparam int BW = DW / 2;

  always_comb begin
    if (hi_i) begin
      pick_o  = {{BW{1'b0}}, word_i[DW-1:BW]};
      merge_o = {byte_i, word_i[BW-1:0]};
    end else begin
      pick_o  = {{BW{1'b0}}, word_i[BW-1:0]};
      merge_o = {word_i[DW-1:BW], byte_i};
    end
  end
endmodule

// File: rtl/bus_dec_psw.sv
`timescale 1ns/1ps
module bus_dec_psw #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_word,
  output logic          wr_ok,
  output logic [DW-1:0] psw,
  output logic          cur_user,
  output logic          prev_user
);
  localparam int CUR_HI  = DW - 1;
  localparam int PREV_HI = DW - 3;

  function automatic logic mode_legal(input logic [1:0] f);
    return (f == 2'b00) || (f == 2'b11);
  endfunction

  always_comb begin
    wr_ok     = mode_legal(wr_word[CUR_HI -: 2]) && mode_legal(wr_word[PREV_HI -: 2]);
    cur_user  = psw[CUR_HI];
    prev_user = psw[PREV_HI];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)               psw <= '0;
    else if (wr_en && wr_ok)  psw <= wr_word;
  end
endmodule

// File: rtl/bus_addr_decoder.sv
`timescale 1ns/1ps
module bus_addr_decoder
  import bus_dec_pkg::*;
#(
  parameter int          AW         = 18,
  parameter int          DW         = 16,
  parameter logic [15:0] SWITCH_VAL = 16'o173030
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_write,
  input  logic            req_byte,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  output logic            rsp_valid,
  output logic [DW-1:0]   rsp_rdata,
  output logic            rsp_err,
  output logic            busy,
  output logic            bus_trap,
  output logic            mode_err,
  output logic [AW-1:0]   fault_addr,
  output logic            mem_req,
  output logic            mem_we,
  output logic [1:0]      mem_be,
  output logic [AW-2:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  output logic [NDEV-1:0] dev_sel,
  output logic            dev_re,
  output logic            dev_we,
  output logic [AW-1:0]   dev_addr,
  output logic [DW-1:0]   dev_wdata,
  input  logic [DW-1:0]   dev_rdata,
  output logic [DW-1:0]   psw,
  output logic            cur_user,
  output logic            prev_user
);
  localparam int BW = DW / 2;

  logic [AW-1:0]   addr_al;
  tgt_e            tgt_c;
  logic            writable_c;
  logic            is_dev, odd_word, trap_c, acc, ok_acc;
  logic [NDEV-1:0] devsel_c;
  logic [DW-1:0]   rd_word, picked, merged;
  logic            psw_wr_en, psw_wr_ok, mode_bad, rmw_start;
  logic [DW-1:0]   psw_wr_word;
  logic [DW-1:0]   lks_q;
  logic            rmw_q;
  logic [NDEV-1:0] rmw_sel_q;
  logic [AW-1:0]   rmw_addr_q;
  logic [DW-1:0]   rmw_data_q;

  assign addr_al = {req_addr[AW-1:1], 1'b0};

  bus_dec_region #(.AW(AW)) u_region (
    .addr_al (addr_al),
    .tgt     (tgt_c),
    .writable(writable_c)
  );

  always_comb begin
    devsel_c = '0;
    is_dev   = 1'b1;
    case (tgt_c)
      TGT_CONS:         devsel_c[DEV_CONS]  = 1'b1;
      TGT_DISK:         devsel_c[DEV_DISK]  = 1'b1;
      TGT_MMUPG:        devsel_c[DEV_MMUPG] = 1'b1;
      TGT_SR0, TGT_SR2: devsel_c[DEV_MMUST] = 1'b1;
      default:          is_dev = 1'b0;
    endcase
  end

  assign req_ready = !rmw_q;
  assign busy      = rmw_q;
  assign odd_word  = !req_byte && req_addr[0];
  assign trap_c    = (tgt_c == TGT_NONE) || odd_word || (req_write && !writable_c);
  assign acc       = req_valid && req_ready;
  assign ok_acc    = acc && !trap_c;
  assign rmw_start = ok_acc && is_dev && req_write && req_byte;

  always_comb begin
    case (tgt_c)
      TGT_MEM:  rd_word = mem_rdata;
      TGT_LCLK: rd_word = lks_q;
      TGT_SWR:  rd_word = DW'(SWITCH_VAL);
      TGT_PSW:  rd_word = psw;
      TGT_SR0, TGT_SR2, TGT_CONS, TGT_DISK, TGT_MMUPG: rd_word = dev_rdata;
      default:  rd_word = '0;
    endcase
  end

  bus_dec_lane #(.DW(DW)) u_lane (
    .word_i (rd_word),
    .hi_i   (req_addr[0]),
    .byte_i (req_wdata[BW-1:0]),
    .pick_o (picked),
    .merge_o(merged)
  );

  assign psw_wr_en   = ok_acc && req_write && (tgt_c == TGT_PSW);
  assign psw_wr_word = req_byte ? merged : req_wdata;
  assign mode_bad    = psw_wr_en && !psw_wr_ok;

  bus_dec_psw #(.DW(DW)) u_psw (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (psw_wr_en),
    .wr_word  (psw_wr_word),
    .wr_ok    (psw_wr_ok),
    .psw      (psw),
    .cur_user (cur_user),
    .prev_user(prev_user)
  );

  // Memory port: byte lanes, no merge needed.
  always_comb begin
    mem_req   = ok_acc && (tgt_c == TGT_MEM);
    mem_we    = req_write;
    mem_addr  = req_addr[AW-1:1];
    mem_be    = req_byte ? (req_addr[0] ? 2'b10 : 2'b01) : 2'b11;
    mem_wdata = req_byte ? {2{req_wdata[BW-1:0]}} : req_wdata;
  end

  // Device port: direct access, or write-back phase of a byte write.
  always_comb begin
    if (rmw_q) begin
      dev_sel   = rmw_sel_q;
      dev_re    = 1'b0;
      dev_we    = 1'b1;
      dev_addr  = rmw_addr_q;
      dev_wdata = rmw_data_q;
    end else begin
      dev_sel   = (ok_acc && is_dev) ? devsel_c : '0;
      dev_re    = ok_acc && is_dev && (!req_write || req_byte);
      dev_we    = ok_acc && is_dev && req_write && !req_byte;
      dev_addr  = addr_al;
      dev_wdata = req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lks_q      <= '0;
      rmw_q      <= 1'b0;
      rmw_sel_q  <= '0;
      rmw_addr_q <= '0;
      rmw_data_q <= '0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
      rsp_err    <= 1'b0;
      bus_trap   <= 1'b0;
      mode_err   <= 1'b0;
      fault_addr <= '0;
    end else begin
      rmw_q <= rmw_start;
      if (rmw_start) begin
        rmw_sel_q  <= devsel_c;
        rmw_addr_q <= addr_al;
        rmw_data_q <= merged;
      end
      if (ok_acc && req_write && (tgt_c == TGT_LCLK))
        lks_q <= req_byte ? merged : req_wdata;
      rsp_valid <= (acc && !rmw_start) || rmw_q;
      rsp_rdata <= (ok_acc && !req_write) ? (req_byte ? picked : rd_word) : '0;
      rsp_err   <= acc && (trap_c || mode_bad);
      bus_trap  <= acc && trap_c;
      mode_err  <= mode_bad;
      if (acc && trap_c) fault_addr <= req_addr;
    end
  end
endmodule

// File: rtl/bus_addr_decoder_chk.sv
`timescale 1ns/1ps
module bus_addr_decoder_chk #(
  parameter int AW = 18,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_byte,
  input logic [AW-1:0] req_addr,
  input logic          rsp_valid,
  input logic          rsp_err,
  input logic          busy,
  input logic          bus_trap,
  input logic          mode_err,
  input logic [AW-1:0] fault_addr,
  input logic          mem_req,
  input logic [3:0]    dev_sel,
  input logic          dev_re,
  input logic          dev_we,
  input logic [DW-1:0] psw,
  input logic          cur_user,
  input logic          prev_user
);
  p_odd_word_trap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_byte && req_addr[0]) |=>
      (bus_trap && fault_addr == $past(req_addr)));

  p_odd_no_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_byte && req_addr[0]) |-> (!mem_req && dev_sel == 4'b0));

  p_trap_resp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_trap |-> (rsp_valid && rsp_err));

  p_mode_resp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |-> (rsp_valid && rsp_err && !bus_trap));

  p_rmw_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);

  p_rmw_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (dev_we && !dev_re && $countones(dev_sel) == 1));

  p_busy_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  p_one_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($onehot0(dev_sel) && !(mem_req && dev_sel != 4'b0)));

  p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |-> ($stable(cur_user) && $stable(prev_user)));

  p_mode_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((psw[DW-1] == psw[DW-2]) && (psw[DW-3] == psw[DW-4])));
endmodule

bind bus_addr_decoder bus_addr_decoder_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_byte(req_byte), .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
  .busy(busy), .bus_trap(bus_trap), .mode_err(mode_err), .fault_addr(fault_addr),
  .mem_req(mem_req), .dev_sel(dev_sel), .dev_re(dev_re), .dev_we(dev_we),
  .psw(psw), .cur_user(cur_user), .prev_user(prev_user)
);

// File: tb/test_bus_addr_decoder.sv
`timescale 1ns/1ps
module test_bus_addr_decoder;
  localparam int AW = 18;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0, req_byte = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, rsp_valid, rsp_err, busy, bus_trap, mode_err;
  logic [DW-1:0] rsp_rdata, mem_wdata, mem_rdata, dev_wdata, dev_rdata, psw;
  logic [AW-1:0] fault_addr, dev_addr;
  logic          mem_req, mem_we, dev_re, dev_we, cur_user, prev_user;
  logic [1:0]    mem_be;
  logic [AW-2:0] mem_addr;
  logic [3:0]    dev_sel;

  int checks = 0, failures = 0, cyc = 0, mem_hits = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bus_addr_decoder i_bus_addr_decoder (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_byte(req_byte), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .busy(busy),
    .bus_trap(bus_trap), .mode_err(mode_err), .fault_addr(fault_addr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_be(mem_be), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .dev_sel(dev_sel), .dev_re(dev_re),
    .dev_we(dev_we), .dev_addr(dev_addr), .dev_wdata(dev_wdata), .dev_rdata(dev_rdata),
    .psw(psw), .cur_user(cur_user), .prev_user(prev_user)
  );

  // Stubs: memory and four devices, decoded on low address bits only.
  logic [DW-1:0] mem_s [256];
  logic [DW-1:0] dev_s [4][8];

  assign mem_rdata = mem_s[mem_addr[7:0]];
  always_comb begin
    dev_rdata = '0;
    for (int k = 0; k < 4; k++)
      if (dev_sel[k]) dev_rdata = dev_s[k][dev_addr[3:1]];
  end
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_req) mem_hits <= mem_hits + 1;
    if (mem_req && mem_we) begin
      if (mem_be[0]) mem_s[mem_addr[7:0]][7:0]  <= mem_wdata[7:0];
      if (mem_be[1]) mem_s[mem_addr[7:0]][15:8] <= mem_wdata[15:8];
    end
    for (int k = 0; k < 4; k++)
      if (dev_we && dev_sel[k]) dev_s[k][dev_addr[3:1]] <= dev_wdata;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic b, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, output logic [DW-1:0] rd,
                        output logic tr, output logic me, output int lat, output logic bz1);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_byte = b; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 1'b0;
    lat = 0; bz1 = 1'b0;
    do begin
      @(negedge clk);
      lat++;
      if (lat == 1) bz1 = busy;
    end while (!rsp_valid && lat < 10);
    rd = rsp_rdata; tr = bus_trap; me = mode_err;
  endtask

  // {write, byte, addr, wdata, exp_rdata, exp_trap, exp_moderr, exp_latency, req}
  localparam int NV = 30;
  localparam logic [59:0] VEC [NV] = '{
    {1'b1,1'b0,18'o001000,16'h1234,16'h0000,1'b0,1'b0,2'd1,4'd1},  // R1 word write
    {1'b0,1'b0,18'o001000,16'h0000,16'h1234,1'b0,1'b0,2'd1,4'd1},  // R1 word read
    {1'b1,1'b1,18'o001001,16'h00AB,16'h0000,1'b0,1'b0,2'd1,4'd7},  // R7 high lane
    {1'b0,1'b0,18'o001000,16'h0000,16'hAB34,1'b0,1'b0,2'd1,4'd7},  // R7 low byte kept
    {1'b0,1'b1,18'o001001,16'h0000,16'h00AB,1'b0,1'b0,2'd1,4'd6},  // R6 odd byte
    {1'b0,1'b1,18'o001000,16'h0000,16'h0034,1'b0,1'b0,2'd1,4'd6},  // R6 even byte
    {1'b0,1'b0,18'o001001,16'h0000,16'h0000,1'b1,1'b0,2'd1,4'd2},  // R2 odd word
    {1'b0,1'b0,18'o777570,16'h0000,16'hF618,1'b0,1'b0,2'd1,4'd4},  // R4 switch
    {1'b1,1'b0,18'o777570,16'h1111,16'h0000,1'b1,1'b0,2'd1,4'd3},  // R3 read-only
    {1'b1,1'b0,18'o777546,16'h0040,16'h0000,1'b0,1'b0,2'd1,4'd4},  // R4 line clock
    {1'b0,1'b0,18'o777546,16'h0000,16'h0040,1'b0,1'b0,2'd1,4'd4},  // R4
    {1'b0,1'b0,18'o760000,16'h0000,16'h0000,1'b1,1'b0,2'd1,4'd3},  // R3 unmapped
    {1'b1,1'b0,18'o777560,16'h5555,16'h0000,1'b0,1'b0,2'd1,4'd5},  // R5 console
    {1'b0,1'b0,18'o777560,16'h0000,16'h5555,1'b0,1'b0,2'd1,4'd5},  // R5
    {1'b1,1'b1,18'o777561,16'h0012,16'h0000,1'b0,1'b0,2'd2,4'd8},  // R8 device byte
    {1'b0,1'b0,18'o777560,16'h0000,16'h1255,1'b0,1'b0,2'd1,4'd8},  // R8 merged
    {1'b1,1'b0,18'o777572,16'h0001,16'h0000,1'b0,1'b0,2'd1,4'd4},  // R4 status 0
    {1'b0,1'b0,18'o777572,16'h0000,16'h0001,1'b0,1'b0,2'd1,4'd4},  // R4
    {1'b1,1'b0,18'o777576,16'h0002,16'h0000,1'b1,1'b0,2'd1,4'd3},  // R3 status 2 write
    {1'b1,1'b0,18'o777776,16'hC000,16'h0000,1'b0,1'b0,2'd1,4'd9},  // R9 user/kernel
    {1'b0,1'b0,18'o777776,16'h0000,16'hC000,1'b0,1'b0,2'd1,4'd9},  // R9
    {1'b1,1'b0,18'o777776,16'h4000,16'h0000,1'b0,1'b1,2'd1,4'd9},  // R9 bad mode
    {1'b0,1'b0,18'o777776,16'h0000,16'hC000,1'b0,1'b0,2'd1,4'd9},  // R9 unchanged
    {1'b1,1'b0,18'o772200,16'h0777,16'h0000,1'b0,1'b0,2'd1,4'd5},  // R5 page regs
    {1'b0,1'b0,18'o772200,16'h0000,16'h0777,1'b0,1'b0,2'd1,4'd5},  // R5
    {1'b1,1'b0,18'o777400,16'h0ABC,16'h0000,1'b0,1'b0,2'd1,4'd5},  // R5 disk
    {1'b0,1'b1,18'o777400,16'h0000,16'h00BC,1'b0,1'b0,2'd1,4'd6},  // R6 device byte
    {1'b1,1'b1,18'o777777,16'h0030,16'h0000,1'b0,1'b0,2'd1,4'd9},  // R9 byte to psw
    {1'b0,1'b0,18'o777776,16'h0000,16'h3000,1'b0,1'b0,2'd1,4'd9},  // R9
    {1'b1,1'b1,18'o777777,16'h0080,16'h0000,1'b0,1'b1,2'd1,4'd9}   // R9 bad via byte
  };

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] rd;
    logic tr, me, bz1;
    int lat, hits0;
    for (int i = 0; i < 256; i++) mem_s[i] = '0;
    for (int k = 0; k < 4; k++) for (int j = 0; j < 8; j++) dev_s[k][j] = '0;
    dev_s[2][7] = 16'hDEAD;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state (R10, R11, R9)
    chk("R11 reset ready", req_ready, 1);
    chk("R11 reset busy", busy, 0);
    chk("R10 reset rsp_valid", rsp_valid, 0);
    chk("R10 reset trap", bus_trap, 0);
    chk("R9 reset psw", psw, 0);
    chk("R9 reset modes", {cur_user, prev_user}, 0);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i][59], VEC[i][58], VEC[i][57:40], VEC[i][39:24], rd, tr, me, lat, bz1);
      chk($sformatf("R%0d row%0d rdata", VEC[i][3:0], i), rd, VEC[i][23:8]);
      chk($sformatf("R%0d row%0d trap", VEC[i][3:0], i), tr, VEC[i][7]);
      chk($sformatf("R%0d row%0d moderr", VEC[i][3:0], i), me, VEC[i][6]);
      chk($sformatf("R10 row%0d latency", i), lat, VEC[i][5:4]);
    end

    // R9: psw is 0x3000 -> kernel current, user previous
    chk("R9 mode outputs", {cur_user, prev_user}, 2'b01);

    // R2: odd word read, no memory strobe, fault address kept
    hits0 = mem_hits;
    access(1'b0, 1'b0, 18'o000003, 16'h0, rd, tr, me, lat, bz1);
    chk("R2 trap", tr, 1);
    chk("R2 fault_addr", fault_addr, 18'o000003);
    chk("R2 no memory strobe", mem_hits - hits0, 0);
    @(negedge clk);
    chk("R10 trap one cycle", bus_trap, 0);

    // R1: memory strobe for a normal access
    hits0 = mem_hits;
    access(1'b0, 1'b0, 18'o000010, 16'h0, rd, tr, me, lat, bz1);
    chk("R1 memory strobe", mem_hits - hits0, 1);

    // R8 / R11: byte write to status 0 through the device port
    access(1'b1, 1'b1, 18'o777573, 16'h007F, rd, tr, me, lat, bz1);
    chk("R8 latency", lat, 2);
    chk("R11 busy during write-back", bz1, 1);
    access(1'b0, 1'b0, 18'o777572, 16'h0, rd, tr, me, lat, bz1);
    chk("R8 merged status 0", rd, 16'h7F01);

    // R5: status word wins over page window overlap
    access(1'b0, 1'b0, 18'o777776, 16'h0, rd, tr, me, lat, bz1);
    chk("R5 priority psw", rd, 16'h3000);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule